// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a down-counter that raises an interrupt to the processor when its count has run out. The counter is clocked by a prescaled tick. Software first writes a timeout value, a prescale select and a run mode. It then issues a start, which loads the count and begins the countdown. A stop freezes the countdown, and a later start resumes from the timeout value.

Every prescaled tick decrements the count. A tick that finds the count already at zero is an expiry. An expiry sets a sticky interrupt flag, and the flag stays set until software clears it. In one-shot mode the timer goes idle at the first expiry and keeps a count of zero until the next start. In reload mode the timer loads the full timeout again at every expiry, so it keeps interrupting at a fixed period of (timeout + 1) × 2^select clock cycles.

Top module: `tick_timer`

## Requirements
- R1: After reset, `irq_o`, `running_o` and `count_o` are all 0, and the stored configuration is timeout 0, select 0 and one-shot mode.
- R2: A start sampled at clock edge E loads the stored timeout into `count_o` and drives `running_o` to 1. Both are visible after E.
- R3: With prescale select p (0..7), a running timer decrements `count_o` once every 2^p clock cycles. The first decrement happens 2^p edges after the start edge.
- R4: With timeout T and select p, `irq_o` rises (T+1)·2^p edges after the start edge. This holds for timeouts from 1 up to the 12-bit maximum 4095.
- R5: In one-shot mode (`cfg_mode_i` = 0), an expiry drives `running_o` to 0 and leaves `count_o` at 0. No further interrupt occurs until the next start.
- R6: In reload mode (`cfg_mode_i` = 1), an expiry loads the timeout back into `count_o` and the timer keeps running. Interrupts then follow every (T+1)·2^p edges.
- R7: A timeout of 0 raises the interrupt on the first prescaled tick, which comes 2^p edges after the start.
- R8: `irq_o` stays set until `irq_clr_i` is sampled high. A clear in the same cycle as an expiry leaves `irq_o` set.
- R9: A stop drives `running_o` to 0 and holds `count_o` unchanged. No interrupt occurs while the timer is stopped.
- R10: A start takes priority over a stop in the same cycle. A start while the timer is running restarts the countdown from the timeout, with the prescaler phase reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Latch timeout, select and mode |
| cfg_timeout_i | input | CNT_W | Timeout value |
| cfg_psel_i | input | PSEL_W | Prescale select p, tick = clock / 2^p |
| cfg_mode_i | input | 1 | 0 = one-shot, 1 = reload |
| start_i | input | 1 | Load timeout and run |
| stop_i | input | 1 | Freeze count and go idle |
| irq_clr_i | input | 1 | Clear interrupt flag |
| irq_o | output | 1 | Sticky interrupt flag |
| running_o | output | 1 | Timer is counting |
| count_o | output | CNT_W | Current count |

## Verification
The bench builds the block with its default widths: a 12-bit count and a 3-bit select. With these widths both ends of the range can be reached in a short run. The bench uses select values 0, 1, 2, 3 and 7 to test tick phases from every clock cycle up to every 128 cycles. It uses the full 4095 timeout to test the top of the count range. Short timeouts with reload are enough to reach the corner cases: a clear that coincides with an expiry, and a start that coincides with a stop.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RELOAD  = 1'b1
  } run_mode_e;
endpackage

// File: rtl/timer_cfg_regs.sv
module timer_cfg_regs import timer_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              mode_i,
  output logic [CNT_W-1:0]  timeout_o,
  output logic [PSEL_W-1:0] psel_o,
  output run_mode_e         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_o <= '0;
      psel_o    <= '0;
      mode_o    <= MODE_ONESHOT;
    end else if (we_i) begin
      timeout_o <= timeout_i;
      psel_o    <= psel_i;
      mode_o    <= run_mode_e'(mode_i);
    end
  end

  assert_cfg_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(timeout_o) && $stable(psel_o) && $stable(mode_o));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);
  localparam int NSEL  = 2 ** PSEL_W;
  localparam int PRE_W = (NSEL > 1) ? NSEL - 1 : 1;

  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  sel_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (run_i)     pre_q <= pre_q + PRE_W'(1);
  end

  // select p ticks when the low p prescaler bits are all ones
  for (genvar p = 0; p < NSEL; p++) begin : g_sel
    if (p == 0) begin : g_every
      assign sel_tick[p] = 1'b1;
    end else begin : g_div
      assign sel_tick[p] = &pre_q[p-1:0];
    end
  end

  assign tick_o = run_i & sel_tick[psel_i];

  assert_restart_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pre_q == '0);
  assert_tick_p0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && psel_i == '0 |-> tick_o);
  assert_no_tick_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o);
endmodule

// File: rtl/timer_core.sv
module timer_core import timer_pkg::*; #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  run_mode_e        mode_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             expire_o
);
  logic at_zero;

  assign at_zero  = (count_o == '0);
  assign expire_o = running_o & tick_i & at_zero & ~start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '0;
      running_o <= 1'b0;
    end else if (start_i) begin
      count_o   <= timeout_i;
      running_o <= 1'b1;
    end else if (stop_i) begin
      running_o <= 1'b0;
    end else if (running_o && tick_i) begin
      if (at_zero) begin
        if (mode_i == MODE_RELOAD) count_o <= timeout_i;
        else                       running_o <= 1'b0;
      end else begin
        count_o <= count_o - CNT_W'(1);
      end
    end
  end

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> running_o && count_o == $past(timeout_i));
  assert_dec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && tick_i && count_o != '0 && !start_i && !stop_i
    |=> count_o == $past(count_o) - CNT_W'(1));
  assert_oneshot_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && mode_i == MODE_ONESHOT |=> !running_o && count_o == '0);
  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o && mode_i == MODE_RELOAD |=> running_o && count_o == $past(timeout_i));
  assert_stop_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !running_o && $stable(count_o));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !start_i |=> !running_o && $stable(count_o));
endmodule

// File: rtl/timer_irq.sv
module timer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i |=> irq_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !irq_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer import timer_pkg::*; #(
  parameter int CNT_W  = 12,
  parameter int PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_timeout_i,
  input  logic [PSEL_W-1:0] cfg_psel_i,
  input  logic              cfg_mode_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              irq_clr_i,
  output logic              irq_o,
  output logic              running_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [CNT_W-1:0]  timeout_q;
  logic [PSEL_W-1:0] psel_q;
  run_mode_e         mode_q;
  logic              tick;
  logic              expire;

  timer_cfg_regs #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .timeout_i (cfg_timeout_i),
    .psel_i    (cfg_psel_i),
    .mode_i    (cfg_mode_i),
    .timeout_o (timeout_q),
    .psel_o    (psel_q),
    .mode_o    (mode_q)
  );

  timer_prescaler #(.PSEL_W(PSEL_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (running_o),
    .restart_i (start_i),
    .psel_i    (psel_q),
    .tick_o    (tick)
  );

  timer_core #(.CNT_W(CNT_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .tick_i    (tick),
    .timeout_i (timeout_q),
    .mode_i    (mode_q),
    .count_o   (count_o),
    .running_o (running_o),
    .expire_o  (expire)
  );

  timer_irq i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (expire),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );

  assert_irq_at_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(count_o) == '0 && $past(running_o));
  assert_no_irq_stopped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !irq_o |=> !irq_o);
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int CNT_W  = 12;
  localparam int PSEL_W = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CNT_W-1:0]  cfg_timeout = '0;
  logic [PSEL_W-1:0] cfg_psel = '0;
  logic              cfg_mode = 1'b0;
  logic              start = 1'b0;
  logic              stop = 1'b0;
  logic              clr_drv = 1'b0;
  logic              clr_mon = 1'b0;
  logic              irq_clr;
  logic              irq;
  logic              running;
  logic [CNT_W-1:0]  count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  bit auto_clr = 1'b1;
  logic irq_prev = 1'b0;

  assign irq_clr = clr_drv | clr_mon;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) i_tick_timer (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we),
    .cfg_timeout_i (cfg_timeout),
    .cfg_psel_i    (cfg_psel),
    .cfg_mode_i    (cfg_mode),
    .start_i       (start),
    .stop_i        (stop),
    .irq_clr_i     (irq_clr),
    .irq_o         (irq),
    .running_o     (running),
    .count_o       (count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: every interrupt rise must match the next queued expected cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      if (irq && !irq_prev) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R5/R9: unexpected interrupt, actual cycle %0d expected none", cyc);
        end else begin
          check("R4/R6/R7 interrupt cycle", cyc, exp_q.pop_front());
        end
        clr_mon = auto_clr;
      end else begin
        clr_mon = 1'b0;
      end
    end
    irq_prev = irq;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  task automatic do_cfg(input int t, input int p, input bit m);
    cfg_we = 1'b1;
    cfg_timeout = CNT_W'(t);
    cfg_psel = PSEL_W'(p);
    cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_start(output int s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    s = cyc;
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    int s;
    int s2;
    int c0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset running", int'(running), 0);
    check("R1 reset count", int'(count), 0);

    // one-shot, select 0
    do_cfg(5, 0, 1'b0);
    do_start(s);
    exp_q.push_back(s + 6);
    check("R2 load count", int'(count), 5);
    check("R2 running", int'(running), 1);
    @(negedge clk);
    check("R3 decrement p=0", int'(count), 4);
    wait_until(s + 6);
    check("R5 idle after expiry", int'(running), 0);
    check("R5 count stays zero", int'(count), 0);
    wait_until(s + 26);
    check("R5 no repeat interrupt", exp_q.size(), 0);

    // one-shot, select 2
    do_cfg(3, 2, 1'b0);
    do_start(s);
    exp_q.push_back(s + 16);
    wait_until(s + 3);
    check("R3 hold before tick p=2", int'(count), 3);
    wait_until(s + 4);
    check("R3 first tick p=2", int'(count), 2);
    wait_until(s + 20);

    // zero timeout
    do_cfg(0, 3, 1'b0);
    do_start(s);
    exp_q.push_back(s + 8);
    wait_until(s + 10);
    do_cfg(0, 7, 1'b0);
    do_start(s);
    exp_q.push_back(s + 128);
    wait_until(s + 127);
    check("R7 no interrupt before tick p=7", int'(irq), 0);
    wait_until(s + 130);

    // maximum timeout
    do_cfg(4095, 0, 1'b0);
    do_start(s);
    exp_q.push_back(s + 4096);
    wait_until(s + 4095);
    check("R4 count at zero before expiry", int'(count), 0);
    check("R4 still running", int'(running), 1);
    wait_until(s + 4098);

    // reload mode, then stop
    do_cfg(2, 1, 1'b1);
    do_start(s);
    exp_q.push_back(s + 6);
    exp_q.push_back(s + 12);
    exp_q.push_back(s + 18);
    wait_until(s + 6);
    check("R6 reload count", int'(count), 2);
    check("R6 still running", int'(running), 1);
    wait_until(s + 20);
    do_stop();
    check("R9 stopped", int'(running), 0);
    check("R9 frozen count value", int'(count), 1);
    c0 = int'(count);
    repeat (10) @(negedge clk);
    check("R9 count held", int'(count), c0);

    // sticky flag and clear racing an expiry
    auto_clr = 1'b0;
    do_cfg(1, 0, 1'b1);
    do_start(s);
    exp_q.push_back(s + 2);
    exp_q.push_back(s + 6);
    wait_until(s + 3);
    clr_drv = 1'b1;
    wait_until(s + 4);
    check("R8 clear loses to expiry", int'(irq), 1);
    wait_until(s + 5);
    check("R8 clear takes effect", int'(irq), 0);
    clr_drv = 1'b0;
    wait_until(s + 6);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R8 flag held", int'(irq), 1);
    repeat (5) @(negedge clk);
    check("R8 flag sticky", int'(irq), 1);
    clr_drv = 1'b1;
    @(negedge clk);
    clr_drv = 1'b0;
    check("R8 flag cleared", int'(irq), 0);
    auto_clr = 1'b1;

    // start and stop in the same cycle while running
    do_cfg(4, 1, 1'b1);
    do_start(s);
    wait_until(s + 5);
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    s2 = cyc;
    check("R10 start wins over stop", int'(running), 1);
    check("R10 restart count", int'(count), 4);
    exp_q.push_back(s2 + 10);
    wait_until(s2 + 11);
    do_stop();
    repeat (5) @(negedge clk);
    check("R6 all expected interrupts seen", exp_q.size(), 0);
    finish_sim();
  end
endmodule